// File: doc/BRIEF.md
# Locality Monitor for Execution Placement

This block keeps a shadow copy of the last-level cache's tag state. It stores no data, only a short slice of each tag, and it reproduces the cache's replacement decisions. It uses that copy to decide where a near-memory operation should run. The host presents the block address of the operation on a lookup port. One cycle later the monitor returns a verdict. A tag hit means the block is probably cached, so the operation runs on the host side. A tag miss means the block is probably not cached, so the operation runs next to memory, and the monitor flags that any host-cached copy must be back-invalidated and written back first.

To keep the shadow in step with the real cache, the monitor takes a second, update-only port. That port is driven on every ordinary last-level cache access and on every operation issued to memory. Each lookup also counts as an access to the shadow. Replacement is true LRU within each set. Storing only a slice of the tag lets two different blocks alias and report a false hit; this is accepted in return for smaller storage.

Top module: `locality_monitor`

## Requirements
- R1: After reset every entry is invalid and `rsp_valid` is low. The first lookup of any block after reset reports low locality.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lkp_valid` high.
- R3: A tag hit gives `rsp_host`=1 and `rsp_backinv`=0. A miss gives `rsp_host`=0 and `rsp_backinv`=1. Both are 0 whenever `rsp_valid` is 0.
- R4: Address bits [5:0] are the byte offset within a 64-byte block and are ignored. The next log2(NUM_SETS) bits select the set. The PTAG_W bits above those form the stored partial tag. All higher bits are ignored, so two blocks that differ only there report a hit on each other.
- R5: An access that misses writes its tag into the least recently used way of its set and makes it the most recently used. Once NUM_WAYS distinct tags have filled a set, one more distinct tag evicts the tag that was used longest ago.
- R6: An access that hits makes that block the most recently used entry, which protects it from the next eviction.
- R7: A lookup updates the array exactly as an update does, so a repeated lookup of a block that just missed reports a hit.
- R8: An update (`upd_valid`) changes the array but produces no response.
- R9: When an update and a lookup arrive in the same cycle and map to the same set, the update takes effect first and the lookup sees its result. This holds both for a hit on the just-updated block and for a miss on a block that the update has just evicted.
- R10: Sets are independent. Accesses to one set never change the verdicts given for another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Cache access or memory-issued operation to record |
| upd_addr | input | ADDR_W | Byte address of the recorded access |
| lkp_valid | input | 1 | Placement lookup request |
| lkp_addr | input | ADDR_W | Byte address of the operation to place |
| rsp_valid | output | 1 | Verdict valid, one cycle after a lookup |
| rsp_host | output | 1 | High locality: run on the host side |
| rsp_backinv | output | 1 | Low locality: run in memory after back-invalidation and writeback |

## Verification
The bench builds the monitor with 2 sets, 4 ways, a 3-bit partial tag and a 12-bit address. With that configuration, filling a set, evicting from it and aliasing on the two ignored upper address bits all take only a handful of accesses. A list-based LRU model in the bench predicts every verdict. Directed sequences cover reset, refresh, eviction and same-cycle collisions. A long pseudo-random sweep then drives both ports over six tags per set, a working set larger than the four ways, so hits, misses and evictions occur in every combination of the two ports.

// File: rtl/locmon_pkg.sv
package locmon_pkg;

    localparam int BLOCK_BYTES = 64;
    localparam int BLOCK_OFF_W = $clog2(BLOCK_BYTES);

    typedef enum logic {
        PLACE_MEMORY = 1'b0,
        PLACE_HOST   = 1'b1
    } place_e;

    typedef struct packed {
        logic   valid;
        place_e place;
    } verdict_t;

    function automatic place_e place_from_hit(input logic hit);
        return hit ? PLACE_HOST : PLACE_MEMORY;
    endfunction

endpackage

// File: rtl/locmon_set_update.sv
// Combinational tag match and LRU age update for one set.
module locmon_set_update #(
    parameter int NUM_WAYS = 16,
    parameter int PTAG_W   = 10,
    localparam int AGE_W   = $clog2(NUM_WAYS)
) (
    input  logic [PTAG_W-1:0]                   tag_i,
    input  logic [NUM_WAYS-1:0]                 vld_i,
    input  logic [NUM_WAYS-1:0][PTAG_W-1:0]     tags_i,
    input  logic [NUM_WAYS-1:0][AGE_W-1:0]      age_i,
    output logic                                hit_o,
    output logic [NUM_WAYS-1:0]                 vld_o,
    output logic [NUM_WAYS-1:0][PTAG_W-1:0]     tags_o,
    output logic [NUM_WAYS-1:0][AGE_W-1:0]      age_o
);
    localparam logic [AGE_W-1:0] OLDEST = AGE_W'(NUM_WAYS - 1);

    logic [NUM_WAYS-1:0] match;
    logic [NUM_WAYS-1:0] victim;
    logic [NUM_WAYS-1:0] touch;
    logic [AGE_W-1:0]    hit_age;
    logic [AGE_W-1:0]    ref_age;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        assign match[w]  = vld_i[w] && (tags_i[w] == tag_i);
        assign victim[w] = (age_i[w] == OLDEST);
    end

    always_comb begin
        hit_age = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (match[w]) hit_age = hit_age | age_i[w];
        end
    end

    assign hit_o   = |match;
    assign ref_age = hit_o ? hit_age : OLDEST;
    assign touch   = hit_o ? match : victim;

    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            vld_o[w]  = vld_i[w];
            tags_o[w] = tags_i[w];
            age_o[w]  = age_i[w];
            if (touch[w]) begin
                vld_o[w]  = 1'b1;
                tags_o[w] = tag_i;
                age_o[w]  = '0;
            end else if (age_i[w] < ref_age) begin
                age_o[w]  = age_i[w] + AGE_W'(1);
            end
        end
    end

endmodule

// File: rtl/locmon_tag_store.sv
// Shadow tag state: two read ports, two write ports; port B wins on a shared set.
module locmon_tag_store #(
    parameter int NUM_SETS = 128,
    parameter int NUM_WAYS = 16,
    parameter int PTAG_W   = 10,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int AGE_W   = $clog2(NUM_WAYS)
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [SET_W-1:0]                    rd_a_set,
    output logic [NUM_WAYS-1:0]                 rd_a_vld,
    output logic [NUM_WAYS-1:0][PTAG_W-1:0]     rd_a_tags,
    output logic [NUM_WAYS-1:0][AGE_W-1:0]      rd_a_age,
    input  logic [SET_W-1:0]                    rd_b_set,
    output logic [NUM_WAYS-1:0]                 rd_b_vld,
    output logic [NUM_WAYS-1:0][PTAG_W-1:0]     rd_b_tags,
    output logic [NUM_WAYS-1:0][AGE_W-1:0]      rd_b_age,
    input  logic                                wr_a_en,
    input  logic [SET_W-1:0]                    wr_a_set,
    input  logic [NUM_WAYS-1:0]                 wr_a_vld,
    input  logic [NUM_WAYS-1:0][PTAG_W-1:0]     wr_a_tags,
    input  logic [NUM_WAYS-1:0][AGE_W-1:0]      wr_a_age,
    input  logic                                wr_b_en,
    input  logic [SET_W-1:0]                    wr_b_set,
    input  logic [NUM_WAYS-1:0]                 wr_b_vld,
    input  logic [NUM_WAYS-1:0][PTAG_W-1:0]     wr_b_tags,
    input  logic [NUM_WAYS-1:0][AGE_W-1:0]      wr_b_age
);
    logic [NUM_WAYS-1:0]             vld_q  [NUM_SETS];
    logic [NUM_WAYS-1:0][PTAG_W-1:0] tags_q [NUM_SETS];
    logic [NUM_WAYS-1:0][AGE_W-1:0]  age_q  [NUM_SETS];

    logic a_shadowed;
    assign a_shadowed = wr_b_en && (wr_b_set == wr_a_set);

    assign rd_a_vld  = vld_q[rd_a_set];
    assign rd_a_tags = tags_q[rd_a_set];
    assign rd_a_age  = age_q[rd_a_set];
    assign rd_b_vld  = vld_q[rd_b_set];
    assign rd_b_tags = tags_q[rd_b_set];
    assign rd_b_age  = age_q[rd_b_set];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                vld_q[s]  <= '0;
                tags_q[s] <= '0;
                for (int w = 0; w < NUM_WAYS; w++) begin
                    age_q[s][w] <= AGE_W'(w);
                end
            end
        end else begin
            if (wr_a_en && !a_shadowed) begin
                vld_q[wr_a_set]  <= wr_a_vld;
                tags_q[wr_a_set] <= wr_a_tags;
                age_q[wr_a_set]  <= wr_a_age;
            end
            if (wr_b_en) begin
                vld_q[wr_b_set]  <= wr_b_vld;
                tags_q[wr_b_set] <= wr_b_tags;
                age_q[wr_b_set]  <= wr_b_age;
            end
        end
    end

endmodule

// File: rtl/locality_monitor.sv
module locality_monitor
    import locmon_pkg::*;
#(
    parameter int ADDR_W   = 48,
    parameter int NUM_SETS = 128,
    parameter int NUM_WAYS = 16,
    parameter int PTAG_W   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              lkp_valid,
    input  logic [ADDR_W-1:0] lkp_addr,
    output logic              rsp_valid,
    output logic              rsp_host,
    output logic              rsp_backinv
);
    localparam int SET_W   = $clog2(NUM_SETS);
    localparam int AGE_W   = $clog2(NUM_WAYS);
    localparam int TAG_LSB = BLOCK_OFF_W + SET_W;
    localparam int TAG_END = TAG_LSB + PTAG_W;

    logic [SET_W-1:0]  upd_set, lkp_set;
    logic [PTAG_W-1:0] upd_tag, lkp_tag;

    assign upd_set = upd_addr[BLOCK_OFF_W +: SET_W];
    assign lkp_set = lkp_addr[BLOCK_OFF_W +: SET_W];
    assign upd_tag = upd_addr[TAG_LSB +: PTAG_W];
    assign lkp_tag = lkp_addr[TAG_LSB +: PTAG_W];

    logic unused_addr_bits;
    assign unused_addr_bits = ^{upd_addr[ADDR_W-1:TAG_END], upd_addr[BLOCK_OFF_W-1:0],
                                lkp_addr[ADDR_W-1:TAG_END], lkp_addr[BLOCK_OFF_W-1:0]};

    // stored state of the two addressed sets
    logic [NUM_WAYS-1:0]             u_vld_rd,  l_vld_rd;
    logic [NUM_WAYS-1:0][PTAG_W-1:0] u_tags_rd, l_tags_rd;
    logic [NUM_WAYS-1:0][AGE_W-1:0]  u_age_rd,  l_age_rd;

    // next state from each path
    logic                            unused_upd_hit;
    logic [NUM_WAYS-1:0]             u_vld_nx,  l_vld_nx;
    logic [NUM_WAYS-1:0][PTAG_W-1:0] u_tags_nx, l_tags_nx;
    logic [NUM_WAYS-1:0][AGE_W-1:0]  u_age_nx,  l_age_nx;

    // lookup input, chained behind the update on a shared set
    logic                            chain;
    logic [NUM_WAYS-1:0]             l_vld_in;
    logic [NUM_WAYS-1:0][PTAG_W-1:0] l_tags_in;
    logic [NUM_WAYS-1:0][AGE_W-1:0]  l_age_in;
    logic                            lkp_hit;

    assign chain     = upd_valid && (upd_set == lkp_set);
    assign l_vld_in  = chain ? u_vld_nx  : l_vld_rd;
    assign l_tags_in = chain ? u_tags_nx : l_tags_rd;
    assign l_age_in  = chain ? u_age_nx  : l_age_rd;

    locmon_tag_store #(
        .NUM_SETS (NUM_SETS),
        .NUM_WAYS (NUM_WAYS),
        .PTAG_W   (PTAG_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_a_set  (upd_set),
        .rd_a_vld  (u_vld_rd),
        .rd_a_tags (u_tags_rd),
        .rd_a_age  (u_age_rd),
        .rd_b_set  (lkp_set),
        .rd_b_vld  (l_vld_rd),
        .rd_b_tags (l_tags_rd),
        .rd_b_age  (l_age_rd),
        .wr_a_en   (upd_valid),
        .wr_a_set  (upd_set),
        .wr_a_vld  (u_vld_nx),
        .wr_a_tags (u_tags_nx),
        .wr_a_age  (u_age_nx),
        .wr_b_en   (lkp_valid),
        .wr_b_set  (lkp_set),
        .wr_b_vld  (l_vld_nx),
        .wr_b_tags (l_tags_nx),
        .wr_b_age  (l_age_nx)
    );

    locmon_set_update #(
        .NUM_WAYS (NUM_WAYS),
        .PTAG_W   (PTAG_W)
    ) u_upd_path (
        .tag_i  (upd_tag),
        .vld_i  (u_vld_rd),
        .tags_i (u_tags_rd),
        .age_i  (u_age_rd),
        .hit_o  (unused_upd_hit),
        .vld_o  (u_vld_nx),
        .tags_o (u_tags_nx),
        .age_o  (u_age_nx)
    );

    locmon_set_update #(
        .NUM_WAYS (NUM_WAYS),
        .PTAG_W   (PTAG_W)
    ) u_lkp_path (
        .tag_i  (lkp_tag),
        .vld_i  (l_vld_in),
        .tags_i (l_tags_in),
        .age_i  (l_age_in),
        .hit_o  (lkp_hit),
        .vld_o  (l_vld_nx),
        .tags_o (l_tags_nx),
        .age_o  (l_age_nx)
    );

    verdict_t verdict_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '{valid: 1'b0, place: PLACE_MEMORY};
        end else begin
            verdict_q <= '{valid: lkp_valid, place: place_from_hit(lkp_hit)};
        end
    end

    assign rsp_valid   = verdict_q.valid;
    assign rsp_host    = verdict_q.valid && (verdict_q.place == PLACE_HOST);
    assign rsp_backinv = verdict_q.valid && (verdict_q.place == PLACE_MEMORY);

endmodule

// File: rtl/locmon_checker.sv
module locmon_checker #(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_addr,
    input logic              lkp_valid,
    input logic [ADDR_W-1:0] lkp_addr,
    input logic              rsp_valid,
    input logic              rsp_host,
    input logic              rsp_backinv
);
    assert_rsp_after_lookup_R2: assert property (@(posedge clk) disable iff (rst)
        lkp_valid |=> rsp_valid);

    assert_no_rsp_without_lookup_R2: assert property (@(posedge clk) disable iff (rst)
        !lkp_valid |=> !rsp_valid);

    assert_quiet_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_host && !rsp_backinv));

    assert_one_placement_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_host != rsp_backinv));

    assert_repeat_lookup_hits_R7: assert property (@(posedge clk) disable iff (rst)
        (lkp_valid && $past(lkp_valid) && (lkp_addr == $past(lkp_addr))) |=> rsp_host);

    assert_update_before_lookup_R9: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && lkp_valid && (upd_addr == lkp_addr)) |=> rsp_host);

endmodule

bind locality_monitor locmon_checker #(.ADDR_W(ADDR_W)) u_locmon_checker (
    .clk         (clk),
    .rst         (rst),
    .upd_valid   (upd_valid),
    .upd_addr    (upd_addr),
    .lkp_valid   (lkp_valid),
    .lkp_addr    (lkp_addr),
    .rsp_valid   (rsp_valid),
    .rsp_host    (rsp_host),
    .rsp_backinv (rsp_backinv)
);

// File: tb/locality_monitor_bench.sv
module locality_monitor_bench;
    localparam int AW    = 12;
    localparam int SETS  = 2;
    localparam int WAYS  = 4;
    localparam int PTW   = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_addr  = '0;
    logic          lkp_valid = 1'b0;
    logic [AW-1:0] lkp_addr  = '0;
    logic          rsp_valid, rsp_host, rsp_backinv;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    locality_monitor #(
        .ADDR_W   (AW),
        .NUM_SETS (SETS),
        .NUM_WAYS (WAYS),
        .PTAG_W   (PTW)
    ) u_locality_monitor (
        .clk         (clk),
        .rst         (rst),
        .upd_valid   (upd_valid),
        .upd_addr    (upd_addr),
        .lkp_valid   (lkp_valid),
        .lkp_addr    (lkp_addr),
        .rsp_valid   (rsp_valid),
        .rsp_host    (rsp_host),
        .rsp_backinv (rsp_backinv)
    );

    // reference model: per set, tags in recency order (index 0 = most recent)
    int rec [SETS][WAYS];
    int fill [SETS];

    function automatic int set_of(input logic [AW-1:0] a);
        return int'(a[6]);
    endfunction

    function automatic int tag_of(input logic [AW-1:0] a);
        return int'(a[9:7]);
    endfunction

    function automatic logic [AW-1:0] mk(input int s, input int t, input int hi, input int off);
        return AW'((hi << 10) | (t << 7) | (s << 6) | (off & 63));
    endfunction

    function automatic bit model_access(input int s, input int t);
        int pos = -1;
        for (int i = 0; i < fill[s]; i++) if (rec[s][i] == t && pos < 0) pos = i;
        if (pos >= 0) begin
            for (int i = pos; i > 0; i--) rec[s][i] = rec[s][i-1];
            rec[s][0] = t;
            return 1'b1;
        end
        if (fill[s] < WAYS) fill[s]++;
        for (int i = fill[s] - 1; i > 0; i--) rec[s][i] = rec[s][i-1];
        rec[s][0] = t;
        return 1'b0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input bit uv, input logic [AW-1:0] ua,
                        input bit lv, input logic [AW-1:0] la, input string req);
        bit exp_hit = 1'b0;
        upd_valid = uv; upd_addr = ua;
        lkp_valid = lv; lkp_addr = la;
        if (uv) void'(model_access(set_of(ua), tag_of(ua)));
        if (lv) exp_hit = model_access(set_of(la), tag_of(la));
        @(posedge clk);
        @(negedge clk);
        upd_valid = 1'b0; lkp_valid = 1'b0;
        check(rsp_valid == lv, req, int'(rsp_valid), int'(lv));
        if (lv) begin
            check(rsp_host == exp_hit, req, int'(rsp_host), int'(exp_hit));
            check(rsp_backinv == !exp_hit, req, int'(rsp_backinv), int'(!exp_hit));
        end else begin
            check(!rsp_host && !rsp_backinv, req, int'({rsp_host, rsp_backinv}), 0);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit [31:0] lfsr = 32'h1234_5678;
        for (int s = 0; s < SETS; s++) fill[s] = 0;
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R1", int'(rsp_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1", int'(rsp_valid), 0);

        // first lookup after reset misses; repeat hits
        step(0, '0, 1, mk(0, 1, 0, 5), "R1");
        step(0, '0, 1, mk(0, 1, 0, 5), "R7");
        // offset and upper bits ignored: alias hits
        step(0, '0, 1, mk(0, 1, 3, 40), "R4");
        // other set is independent
        step(0, '0, 1, mk(1, 1, 0, 0), "R10");
        // updates give no response but fill the set
        step(1, mk(0, 2, 0, 0), 0, '0, "R8");
        step(1, mk(0, 3, 1, 9), 0, '0, "R8");
        step(0, '0, 1, mk(0, 2, 0, 0), "R8");
        step(1, mk(0, 4, 0, 0), 0, '0, "R8");
        // refresh tag 1, then a new tag evicts tag 3
        step(0, '0, 1, mk(0, 1, 0, 0), "R6");
        step(1, mk(0, 5, 0, 0), 0, '0, "R5");
        step(0, '0, 1, mk(0, 1, 0, 0), "R6");
        step(0, '0, 1, mk(0, 3, 0, 0), "R5");
        step(0, '0, 1, mk(0, 2, 0, 0), "R5");
        // set 1 untouched by set 0 traffic
        step(0, '0, 1, mk(1, 1, 0, 0), "R10");
        // same-cycle collision: update first
        step(1, mk(1, 6, 0, 0), 1, mk(1, 6, 2, 0), "R9");
        step(1, mk(1, 0, 0, 0), 0, '0, "R9");
        step(1, mk(1, 2, 0, 0), 0, '0, "R9");
        step(1, mk(1, 7, 0, 0), 1, mk(1, 1, 0, 0), "R9");
        step(0, '0, 1, mk(1, 7, 0, 0), "R9");

        // pseudo-random sweep of both ports
        for (int n = 0; n < 4000; n++) begin
            bit uv, lv;
            logic [AW-1:0] ua, la;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            uv = lfsr[0];
            lv = lfsr[1] | lfsr[2];
            ua = mk(int'(lfsr[3]), int'(lfsr[8:6]) % 6, int'(lfsr[10:9]), int'(lfsr[16:11]));
            la = mk(int'(lfsr[4]), int'(lfsr[20:18]) % 6, int'(lfsr[22:21]), int'(lfsr[28:23]));
            step(uv, ua, lv, la, "R5");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule